// File: doc/BRIEF.md
# HDLC Transmit FIFO with Packet-Length Tagging

This block sits between a host and an HDLC framer on the transmit side. The host pushes frame bytes one at a time into a byte-wide queue. The framer pulls them out in order. Each stored entry carries a ninth bit that marks the last byte of a packet. The framer uses that bit to know when to close the frame. The host never sets the bit by hand. A 7-bit down-counter, loaded with a programmed packet length, counts accepted writes. It marks the write that arrives while the counter reads one.

When the reload option is on, the counter reloads the programmed length after each marked write. Every packet of that length is then marked without any further host action. When the option is off, the counter parks at zero after the marked write, and nothing more is marked until a new length is programmed. The host can read the counter position at any time. A registered two-bit fill status, with a threshold at 16 entries, tells the host whether to keep writing. A sticky flag records any write that was dropped because the queue was full.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: After reset the fill status is 2'b10 (empty), the counter position reads 0 and the overflow flag is low.
- R2: Bytes leave in the order they were accepted. The head entry is always visible on the read outputs, and a read strobe removes it. A read strobe while the queue is empty has no effect.
- R3: A length write loads both the programmed length and the counter, and the counter is visible on the position output after that edge. A length write in the same cycle as a byte write takes precedence over that write's decrement.
- R4: Each accepted byte write with no length write lowers the counter by one at that clock edge, if the counter is above one.
- R5: A byte accepted while the counter reads one is stored with its end-of-packet bit set (bit 8 of the entry). That bit appears on the end-of-packet output when the byte reaches the head. All other bytes carry the bit clear.
- R6: With the reload input high, the end-of-packet write reloads the counter with the programmed length.
- R7: With the reload input low, the end-of-packet write leaves the counter at 0. Writes at 0 are not tagged and do not change the counter.
- R8: A byte write while the queue holds DEPTH entries is dropped and leaves the counter unchanged. It also sets the overflow flag, which stays high until reset.
- R9: The fill status is 2'b00 when full, 2'b01 for THRESH or more entries but not full, 2'b10 when empty, and 2'b11 for 1 to THRESH-1 entries. It follows the fill count with one clock of lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host byte write strobe |
| wrData | input | 8 | Host byte |
| rdEn | input | 1 | Framer read strobe (removes head entry) |
| rdData | output | 8 | Head byte |
| rdEop | output | 1 | End-of-packet bit of head entry |
| lenWrEn | input | 1 | Packet-length write strobe |
| lenData | input | 7 | Packet length |
| cycleEn | input | 1 | Reload counter after each tagged write |
| cntPos | output | 7 | Current counter position |
| txStat | output | 2 | Registered fill status |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench uses the default depth of 32 and threshold of 16. At that size, 33 back-to-back writes reach the full boundary, the dropped-write path and every status code within a few dozen cycles. Random programmed lengths are kept between 0 and 20, so packets end often inside the queue and both reload and park behaviour occur many times. The 7-bit counter range is exercised directly by one directed length of 100. That case also shows that dropped writes do not decrement the counter.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic tag;
  } txqStrobe_t;

  localparam logic [1:0] ST_FULL  = 2'b00;
  localparam logic [1:0] ST_HIGH  = 2'b01;
  localparam logic [1:0] ST_EMPTY = 2'b10;
  localparam logic [1:0] ST_LOW   = 2'b11;
endpackage

// File: rtl/txq_datapath.sv
module txq_datapath
  import txq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txqStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  output logic [FILL_W-1:0] fill
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= {stb.tag, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
      case ({stb.push, stb.pop})
        2'b10:   fill <= fill + FILL_W'(1);
        2'b01:   fill <= fill - FILL_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign {rdEop, rdData} = mem[rdPtr];

  // R8: control must never push into a full queue
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.push && fill == FILL_W'(DEPTH)));
  // R2: control must never pop an empty queue
  p_no_pop_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.pop && fill == '0));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  parameter int CNT_W  = 7,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              lenWrEn,
  input  logic [CNT_W-1:0]  lenData,
  input  logic              cycleEn,
  input  logic [FILL_W-1:0] fill,
  output txqStrobe_t        stb,
  output logic [CNT_W-1:0]  cntPos,
  output logic [1:0]        txStat,
  output logic              overflow
);
  localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(DEPTH);
  localparam logic [FILL_W-1:0] THR_LVL  = FILL_W'(THRESH);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  logic [CNT_W-1:0] lenReg;
  logic             isFull, isEmpty;

  assign isFull   = (fill == FULL_LVL);
  assign isEmpty  = (fill == '0);
  assign stb.push = wrEn && !isFull;
  assign stb.pop  = rdEn && !isEmpty;
  assign stb.tag  = stb.push && (cntPos == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg <= '0;
      cntPos <= '0;
    end else if (lenWrEn) begin
      lenReg <= lenData;
      cntPos <= lenData;
    end else if (stb.push) begin
      if (cntPos == ONE)    cntPos <= cycleEn ? lenReg : '0;
      else if (cntPos != '0) cntPos <= cntPos - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txStat <= ST_EMPTY;
    else if (isFull)           txStat <= ST_FULL;
    else if (isEmpty)          txStat <= ST_EMPTY;
    else if (fill >= THR_LVL)  txStat <= ST_HIGH;
    else                       txStat <= ST_LOW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                overflow <= 1'b0;
    else if (wrEn && isFull)  overflow <= 1'b1;
  end

  // R4: plain accepted write steps the counter down
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !lenWrEn && cntPos > ONE) |=> cntPos == $past(cntPos) - ONE);
  // R6: reload after tagged write
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !lenWrEn && cntPos == ONE && cycleEn) |=> cntPos == $past(lenReg));
  // R7: park at zero after tagged write
  p_park_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !lenWrEn && cntPos == ONE && !cycleEn) |=> cntPos == '0);
  // R3: length write loads the counter
  p_len_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    lenWrEn |=> cntPos == $past(lenData));
  // R8: overflow is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R9: status lags fill by one edge
  p_stat_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fill == FULL_LVL) |=> txStat == ST_FULL);
  p_stat_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fill == '0) |=> txStat == ST_EMPTY);
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import txq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEop,
  input  logic              lenWrEn,
  input  logic [CNT_W-1:0]  lenData,
  input  logic              cycleEn,
  output logic [CNT_W-1:0]  cntPos,
  output logic [1:0]        txStat,
  output logic              overflow
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  txqStrobe_t        stb;
  logic [FILL_W-1:0] fill;

  txq_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W), .FILL_W(FILL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .lenWrEn(lenWrEn),
    .lenData(lenData), .cycleEn(cycleEn), .fill(fill), .stb(stb),
    .cntPos(cntPos), .txStat(txStat), .overflow(overflow)
  );

  txq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FILL_W(FILL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .rdEop(rdEop), .fill(fill)
  );
endmodule

// File: tb/sim_hdlc_tx_fifo.sv
module sim_hdlc_tx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int THRESH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, lenWrEn = 1'b0, cycleEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [6:0] lenData = '0;
  logic [7:0] rdData;
  logic       rdEop;
  logic [6:0] cntPos;
  logic [1:0] txStat;
  logic       overflow;

  int total = 0, bad = 0;
  bit done = 0;

  logic [8:0] q[$];
  int         mFill = 0;
  logic [6:0] mCnt = '0, mLen = '0;
  logic [1:0] mStat = 2'b10;
  logic       mOvf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_fifo u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rdEop(rdEop), .lenWrEn(lenWrEn), .lenData(lenData),
    .cycleEn(cycleEn), .cntPos(cntPos), .txStat(txStat), .overflow(overflow)
  );

  function automatic logic [1:0] enc(input int f);
    if (f == DEPTH) return 2'b00;
    if (f == 0) return 2'b10;
    if (f >= THRESH) return 2'b01;
    return 2'b11;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R9 status", 32'(txStat), 32'(mStat));
    chk("R4 counter", 32'(cntPos), 32'(mCnt));
    chk("R8 overflow", 32'(overflow), 32'(mOvf));
    if (q.size() > 0) begin
      chk("R2 data order", 32'(rdData), 32'(q[0][7:0]));
      chk("R5 eop tag", 32'(rdEop), 32'(q[0][8]));
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic l, input logic [6:0] ld, input logic c);
    logic push, pop, tag;
    compareAll();
    wrEn = w; wrData = d; rdEn = r; lenWrEn = l; lenData = ld; cycleEn = c;
    push = w && (mFill < DEPTH);
    pop  = r && (mFill > 0);
    tag  = push && (mCnt == 7'd1);
    mStat = enc(mFill);
    if (w && mFill == DEPTH) mOvf = 1'b1;
    if (pop) void'(q.pop_front());
    if (push) q.push_back({tag, d});
    mFill = q.size();
    if (l) begin
      mLen = ld; mCnt = ld;
    end else if (push) begin
      if (mCnt == 7'd1) mCnt = c ? mLen : 7'd0;
      else if (mCnt != 7'd0) mCnt = mCnt - 7'd1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic c);
    step(1'b0, 8'h00, 1'b0, 1'b0, 7'd0, c);
  endtask

  task automatic drain();
    while (q.size() > 0) step(1'b0, 8'h00, 1'b1, 1'b0, 7'd0, cycleEn);
    idle(cycleEn);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 status", 32'(txStat), 32'(2'b10));
    chk("R1 counter", 32'(cntPos), 32'd0);
    chk("R1 overflow", 32'(overflow), 32'd0);

    // R3 load, then precedence over a concurrent write
    step(1'b0, 8'h00, 1'b0, 1'b1, 7'd3, 1'b0);
    chk("R3 load", 32'(cntPos), 32'd3);
    step(1'b1, 8'hA1, 1'b0, 1'b1, 7'd5, 1'b0);
    chk("R3 precedence", 32'(cntPos), 32'd5);
    drain();

    // R7 park at zero: length 2, write four bytes
    step(1'b0, 8'h00, 1'b0, 1'b1, 7'd2, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h10 + i), 1'b0, 1'b0, 7'd0, 1'b0);
    chk("R7 parked", 32'(cntPos), 32'd0);
    chk("R7 tag second only", 32'({q[0][8], q[1][8], q[2][8], q[3][8]}), 32'b0100);
    drain();

    // R6 reload: length 3, seven bytes -> tags at 3 and 6, counter 2
    step(1'b0, 8'h00, 1'b0, 1'b1, 7'd3, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b1, 8'(8'h30 + i), 1'b0, 1'b0, 7'd0, 1'b1);
    chk("R6 reload position", 32'(cntPos), 32'd2);
    chk("R6 second tag", 32'(q[5][8]), 32'd1);
    drain();

    // R8 full: length 100, 40 writes, no reads
    step(1'b0, 8'h00, 1'b0, 1'b1, 7'd100, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b1, 8'(i), 1'b0, 1'b0, 7'd0, 1'b0);
    idle(1'b0);
    chk("R8 no decrement when full", 32'(cntPos), 32'd68);
    chk("R8 overflow set", 32'(overflow), 32'd1);
    chk("R9 full code", 32'(txStat), 32'(2'b00));
    drain();
    chk("R8 overflow sticky", 32'(overflow), 32'd1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic w, r, l, c;
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 45;
      l = ($urandom % 64) == 0;
      c = (($urandom % 200) == 0) ? ~cycleEn : cycleEn;
      step(w, 8'($urandom), r, l, 7'($urandom % 21), c);
    end
    compareAll();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule